// File: doc/BRIEF.md
# Run-time programmable transposed-form FIR filter

This block is a fixed-point finite impulse response filter built in the transposed structure. Every accepted input sample is multiplied by all coefficients in the same cycle. Each product is added into a chain of partial-sum registers, and the head of that chain forms the filtered result. The taps are not fixed when the block is built. A host loads them at run time through an AXI4-Lite slave, and it can read them back to confirm the write path.

Samples enter on an AXI4-Stream slave and results leave on an AXI4-Stream master. Both buses are 32 bits wide. A single run bit gates input acceptance. Back-pressure on the output stalls the whole chain, so no sample is dropped and none is counted twice. The end-of-packet marker of each input beat travels with the result computed from that beat.

All three interfaces share one clock and one synchronous active-high reset.

Top module: `xpose_fir`

## Requirements
- R1: For the n-th accepted input x (the low DW bits of `in_tdata`, signed two's complement), the output word is the sum over k of c[k]·x[n-k], with samples before the last reset taken as zero. It is sign-extended to 32 bits, or cut to its low 32 bits when the full-precision width 2·DW+ceil(log2(TAPS)) exceeds 32. It is valid on `out_tvalid` from the clock edge that accepts the sample.
- R2: Register map, in bytes. Offset 0x0 holds the run bit in data bit 0. Coefficient k (k = 0..TAPS-1) sits at offset 4·(k+1), in the low DW bits of the word. A read returns the last value written, with all unused bits zero. Read data comes with `cfg_rvalid` and is held until `cfg_rready`.
- R3: Writes honour `cfg_wstrb`. Strobe bit b enables data byte b, bits [8b+7:8b]. Bytes whose strobe is 0 keep their old contents.
- R4: Every write response and every read response is OKAY (2'b00). A read of an offset outside the map returns zero. A write to such an offset changes no register. `cfg_bvalid` is held until `cfg_bready`.
- R5: `in_tready` is high only when the run bit is 1 and the output register is empty or is being drained in that cycle. With the run bit at 0, no input is accepted.
- R6: While `out_tvalid` is high and `out_tready` is low, `out_tdata` and `out_tlast` hold steady. Under any pattern of output back-pressure, every accepted sample yields exactly one output beat, in order.
- R7: `out_tlast` equals the `in_tlast` of the input beat the result came from. `out_tstrb` is all ones.
- R8: A coefficient rewritten while the filter holds history applies from the next accepted sample. The partial sums are not flushed, so products formed earlier keep the old value.
- R9: Reset clears the run bit, every coefficient, every partial sum and the output valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all three interfaces |
| rst | input | 1 | Synchronous reset, active high |
| cfg_awaddr | input | ADDR_W | Write address, in bytes |
| cfg_awprot | input | 3 | Write protection field, ignored |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address accepted |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Byte enables for the write data |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data accepted |
| cfg_bresp | output | 2 | Write response, always OKAY |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response taken |
| cfg_araddr | input | ADDR_W | Read address, in bytes |
| cfg_arprot | input | 3 | Read protection field, ignored |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address accepted |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response, always OKAY |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data taken |
| in_tdata | input | 32 | Input sample, in the low DW bits, signed |
| in_tstrb | input | 4 | Input byte qualifiers, ignored |
| in_tlast | input | 1 | End-of-packet marker of the input beat |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat accepted |
| out_tdata | output | 32 | Filtered result |
| out_tstrb | output | 4 | Output byte qualifiers, all ones |
| out_tlast | output | 1 | Forwarded end-of-packet marker |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Output beat taken |

## Verification
A filtered result is due on the output register at the same clock edge that accepts its sample. The bench therefore computes the expected word at the moment it sees the handshake will occur, queues it, and compares beats in order at the falling edge after each output handshake.

Read data appears one edge after the address handshake, and a write response one edge after the combined address and data handshake. Each register check is sampled just after that edge.

A coefficient rewrite is due on the next accepted sample. To match this, the bench keeps a snapshot of the coefficient set for every sample, and each expected sum pairs every past sample with the coefficients that were in force when that sample was accepted. All stimulus is driven on falling edges, so ready and valid are settled before each rising edge.

// File: rtl/xfir_pkg.sv
package xfir_pkg;
  localparam int AXI_DW = 32;
  localparam int AXI_SW = AXI_DW / 8;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/xfir_regbank.sv
module xfir_regbank
  import xfir_pkg::*;
#(
  parameter int TAPS   = 53,
  parameter int DW     = 16,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         awaddr_i,
  input  logic                      awvalid_i,
  output logic                      awready_o,
  input  logic [AXI_DW-1:0]         wdata_i,
  input  logic [AXI_SW-1:0]         wstrb_i,
  input  logic                      wvalid_i,
  output logic                      wready_o,
  output logic                      bvalid_o,
  input  logic                      bready_i,
  input  logic [ADDR_W-1:0]         araddr_i,
  input  logic                      arvalid_i,
  output logic                      arready_o,
  output logic [AXI_DW-1:0]         rdata_o,
  output logic                      rvalid_o,
  input  logic                      rready_i,
  output logic                      run_o,
  output logic [TAPS-1:0][DW-1:0]   coef_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr_fire;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [AXI_DW-1:0] rd_val;
  wire unused_addr_lsb = ^{awaddr_i[1:0], araddr_i[1:0]};

  function automatic logic [DW-1:0] strobe_merge(input logic [DW-1:0] old_v,
                                                 input logic [AXI_DW-1:0] new_w,
                                                 input logic [AXI_SW-1:0] strb);
    logic [AXI_DW-1:0] r;
    r = '0;
    r[DW-1:0] = old_v;
    for (int b = 0; b < AXI_SW; b++)
      if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r[DW-1:0];
  endfunction

  assign wr_idx    = awaddr_i[ADDR_W-1:2];
  assign rd_idx    = araddr_i[ADDR_W-1:2];
  assign awready_o = awvalid_i && wvalid_i && !bvalid_o;
  assign wready_o  = awready_o;
  assign wr_fire   = awready_o;
  assign arready_o = !rvalid_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o    <= 1'b0;
      bvalid_o <= 1'b0;
    end else begin
      if (wr_fire) begin
        bvalid_o <= 1'b1;
        if (wr_idx == '0 && wstrb_i[0]) run_o <= wdata_i[0];
      end else if (bready_i) begin
        bvalid_o <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap_reg
    logic [DW-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst)
        c_q <= '0;
      else if (wr_fire && wr_idx == IDX_W'(k + 1))
        c_q <= strobe_merge(c_q, wdata_i, wstrb_i);
    end
    assign coef_o[k] = c_q;
  end

  always_comb begin
    rd_val = '0;
    if (rd_idx == '0) rd_val[0] = run_o;
    for (int k = 0; k < TAPS; k++)
      if (rd_idx == IDX_W'(k + 1)) rd_val[DW-1:0] = coef_o[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_o <= 1'b1;
      rdata_o  <= rd_val;
    end else if (rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/xfir_mac_chain.sv
module xfir_mac_chain #(
  parameter int TAPS  = 53,
  parameter int DW    = 16,
  parameter int ACC_W = 2 * DW + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_i,
  input  logic signed [DW-1:0]     sample_i,
  input  logic [TAPS-1:0][DW-1:0]  coef_i,
  output logic signed [ACC_W-1:0]  y_o
);
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] psum [1:TAPS];

  assign x_ext      = ACC_W'(sample_i);
  assign psum[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    logic signed [ACC_W-1:0] c_ext;
    assign c_ext   = ACC_W'($signed(coef_i[k]));
    assign prod[k] = c_ext * x_ext;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_psum
    logic signed [ACC_W-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst)         acc_q <= '0;
      else if (step_i) acc_q <= prod[k] + psum[k+1];
    end
    assign psum[k] = acc_q;
  end

  assign y_o = prod[0] + psum[1];
endmodule

// File: rtl/xfir_stream_out.sv
module xfir_stream_out
  import xfir_pkg::*;
#(
  parameter int ACC_W = 38
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_i,
  input  logic                     in_tvalid_i,
  input  logic                     in_tlast_i,
  output logic                     in_tready_o,
  output logic                     step_o,
  input  logic signed [ACC_W-1:0]  y_i,
  output logic [AXI_DW-1:0]        out_tdata_o,
  output logic                     out_tlast_o,
  output logic                     out_tvalid_o,
  input  logic                     out_tready_i
);
  logic [AXI_DW-1:0] word;

  if (ACC_W > AXI_DW) begin : g_cut
    assign word = y_i[AXI_DW-1:0];
    wire unused_hi = ^y_i[ACC_W-1:AXI_DW];
  end else begin : g_sext
    assign word = AXI_DW'(y_i);
  end

  assign in_tready_o = run_i && (!out_tvalid_o || out_tready_i);
  assign step_o      = in_tvalid_i && in_tready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tvalid_o <= 1'b0;
      out_tdata_o  <= '0;
      out_tlast_o  <= 1'b0;
    end else if (step_o) begin
      out_tvalid_o <= 1'b1;
      out_tdata_o  <= word;
      out_tlast_o  <= in_tlast_i;
    end else if (out_tready_i) begin
      out_tvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/xpose_fir.sv
module xpose_fir
  import xfir_pkg::*;
#(
  parameter int TAPS   = 53,
  parameter int DW     = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_awaddr,
  input  logic [2:0]        cfg_awprot,
  input  logic              cfg_awvalid,
  output logic              cfg_awready,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_wstrb,
  input  logic              cfg_wvalid,
  output logic              cfg_wready,
  output logic [1:0]        cfg_bresp,
  output logic              cfg_bvalid,
  input  logic              cfg_bready,
  input  logic [ADDR_W-1:0] cfg_araddr,
  input  logic [2:0]        cfg_arprot,
  input  logic              cfg_arvalid,
  output logic              cfg_arready,
  output logic [31:0]       cfg_rdata,
  output logic [1:0]        cfg_rresp,
  output logic              cfg_rvalid,
  input  logic              cfg_rready,
  input  logic [31:0]       in_tdata,
  input  logic [3:0]        in_tstrb,
  input  logic              in_tlast,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [31:0]       out_tdata,
  output logic [3:0]        out_tstrb,
  output logic              out_tlast,
  output logic              out_tvalid,
  input  logic              out_tready
);
  localparam int ACC_W = 2 * DW + $clog2(TAPS);

  logic                    run;
  logic [TAPS-1:0][DW-1:0] coef;
  logic                    step;
  logic signed [ACC_W-1:0] y;
  logic signed [DW-1:0]    sample;

  wire unused_side = ^{cfg_awprot, cfg_arprot, in_tstrb};
  if (DW < AXI_DW) begin : g_hi_unused
    wire unused_tdata_hi = ^in_tdata[AXI_DW-1:DW];
  end

  assign sample    = $signed(in_tdata[DW-1:0]);
  assign cfg_bresp = RESP_OKAY;
  assign cfg_rresp = RESP_OKAY;
  assign out_tstrb = '1;

  xfir_regbank #(.TAPS(TAPS), .DW(DW), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .awaddr_i(cfg_awaddr), .awvalid_i(cfg_awvalid), .awready_o(cfg_awready),
    .wdata_i(cfg_wdata), .wstrb_i(cfg_wstrb), .wvalid_i(cfg_wvalid), .wready_o(cfg_wready),
    .bvalid_o(cfg_bvalid), .bready_i(cfg_bready),
    .araddr_i(cfg_araddr), .arvalid_i(cfg_arvalid), .arready_o(cfg_arready),
    .rdata_o(cfg_rdata), .rvalid_o(cfg_rvalid), .rready_i(cfg_rready),
    .run_o(run), .coef_o(coef)
  );

  xfir_mac_chain #(.TAPS(TAPS), .DW(DW), .ACC_W(ACC_W)) mac_i (
    .clk(clk), .rst(rst), .step_i(step), .sample_i(sample), .coef_i(coef), .y_o(y)
  );

  xfir_stream_out #(.ACC_W(ACC_W)) sout_i (
    .clk(clk), .rst(rst), .run_i(run),
    .in_tvalid_i(in_tvalid), .in_tlast_i(in_tlast), .in_tready_o(in_tready),
    .step_o(step), .y_i(y),
    .out_tdata_o(out_tdata), .out_tlast_o(out_tlast),
    .out_tvalid_o(out_tvalid), .out_tready_i(out_tready)
  );
endmodule

// File: rtl/xpose_fir_chk.sv
module xpose_fir_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_tvalid,
  input logic        in_tready,
  input logic        out_tvalid,
  input logic        out_tready,
  input logic [31:0] out_tdata,
  input logic        out_tlast,
  input logic        cfg_bvalid,
  input logic        cfg_bready,
  input logic        cfg_rvalid,
  input logic        cfg_rready,
  input logic [31:0] cfg_rdata
);
  // R1: an accepted sample produces an output beat on the next edge
  assert_accept_to_valid_R1: assert property (@(posedge clk) disable iff (rst)
    in_tvalid && in_tready |=> out_tvalid);

  // R5: no input is taken while a stalled result occupies the output
  assert_no_take_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |-> !in_tready);

  // R6: a stalled output beat holds its contents
  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast));

  // R6: a drained beat with no new input leaves the output empty
  assert_drain_empties_R6: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && out_tready && !(in_tvalid && in_tready) |=> !out_tvalid);

  // R4: a write response waits for the host
  assert_bresp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_bvalid && !cfg_bready |=> cfg_bvalid);

  // R2: read data waits for the host unchanged
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid && !cfg_rready |=> cfg_rvalid && $stable(cfg_rdata));
endmodule

bind xpose_fir xpose_fir_chk chk_i (
  .clk(clk), .rst(rst),
  .in_tvalid(in_tvalid), .in_tready(in_tready),
  .out_tvalid(out_tvalid), .out_tready(out_tready),
  .out_tdata(out_tdata), .out_tlast(out_tlast),
  .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
  .cfg_rvalid(cfg_rvalid), .cfg_rready(cfg_rready), .cfg_rdata(cfg_rdata)
);

// File: tb/xpose_fir_tb_top.sv
module xpose_fir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 4;
  localparam int DW = 12;
  localparam int AW = 12;
  localparam int HIST = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] cfg_awaddr = '0, cfg_araddr = '0;
  logic [2:0]  cfg_awprot = 3'b101, cfg_arprot = 3'b010;
  logic        cfg_awvalid = 0, cfg_wvalid = 0, cfg_arvalid = 0;
  logic        cfg_bready = 1, cfg_rready = 1;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_wstrb = '0;
  logic        cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
  logic [1:0]  cfg_bresp, cfg_rresp;
  logic [31:0] cfg_rdata;
  logic [31:0] in_tdata = '0;
  logic [3:0]  in_tstrb = 4'h5;
  logic        in_tlast = 0, in_tvalid = 0, in_tready;
  logic [31:0] out_tdata;
  logic [3:0]  out_tstrb;
  logic        out_tlast, out_tvalid;
  logic        out_tready = 1;

  int checks = 0, errors = 0;
  int n_in = 0, n_out = 0, hist_base = 0;
  int bp_mode = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic signed [DW-1:0] coef_m [TAPS];
  longint xs [HIST];
  longint cs [HIST][TAPS];
  longint exp_val [HIST];
  bit     exp_last [HIST];
  logic [31:0] e_word;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpose_fir #(.TAPS(TAPS), .DW(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_awaddr(cfg_awaddr), .cfg_awprot(cfg_awprot), .cfg_awvalid(cfg_awvalid),
    .cfg_awready(cfg_awready), .cfg_wdata(cfg_wdata), .cfg_wstrb(cfg_wstrb),
    .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready), .cfg_bresp(cfg_bresp),
    .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready), .cfg_araddr(cfg_araddr),
    .cfg_arprot(cfg_arprot), .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready),
    .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp), .cfg_rvalid(cfg_rvalid),
    .cfg_rready(cfg_rready), .in_tdata(in_tdata), .in_tstrb(in_tstrb),
    .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tstrb(out_tstrb), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready)
  );

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // output sink: ready pattern by mode (0 always, 1 pseudo-random, 2 never)
  always @(negedge clk) begin
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    if (bp_mode == 1)      out_tready = lcg[20] | lcg[9];
    else if (bp_mode == 2) out_tready = 1'b0;
    else                   out_tready = 1'b1;
  end

  // output monitor: beats compared in order against the queued expectations
  always @(negedge clk) begin
    #2;
    if (!rst && out_tvalid && out_tready) begin
      if (n_out >= n_in) begin
        chk("R6", "unexpected output beat", n_out, n_in - 1);
      end else begin
        e_word = exp_val[n_out][31:0];
        chk("R1", "filtered word", out_tdata, e_word);
        chk("R7", "forwarded tlast", out_tlast, exp_last[n_out]);
        chk("R7", "tstrb all ones", out_tstrb, 4'hF);
        n_out++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    hist_base = n_in;
    n_out = n_in;
    for (int k = 0; k < TAPS; k++) coef_m[k] = '0;
  endtask

  task automatic axil_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cfg_awaddr = a; cfg_wdata = d; cfg_wstrb = s;
    cfg_awvalid = 1; cfg_wvalid = 1;
    #1;
    while (!cfg_awready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_awvalid = 0; cfg_wvalid = 0;
    chk("R4", "write response valid", cfg_bvalid, 1);
    chk("R4", "write response OKAY", cfg_bresp, 0);
  endtask

  task automatic axil_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_araddr = a; cfg_arvalid = 1;
    #1;
    while (!cfg_arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cfg_arvalid = 0;
    chk("R4", "read response OKAY", cfg_rresp, 0);
    d = cfg_rvalid ? cfg_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic set_coef(input int k, input logic [31:0] d);
    axil_write(AW'(4 * (k + 1)), d, 4'hF);
    coef_m[k] = d[DW-1:0];
  endtask

  task automatic set_run(input bit r);
    axil_write('0, {31'h5A5A_5A5A, r}, 4'hF);
  endtask

  // pushes one sample; expected value computed when the handshake is certain
  task automatic push(input logic [DW-1:0] x, input bit last);
    longint y;
    @(negedge clk);
    in_tdata = {20'hC3A5F, x};
    in_tlast = last;
    in_tvalid = 1;
    #1;
    while (!in_tready) begin @(negedge clk); #1; end
    xs[n_in] = longint'($signed(x));
    for (int k = 0; k < TAPS; k++) cs[n_in][k] = longint'(coef_m[k]);
    y = 0;
    for (int k = 0; k < TAPS; k++)
      if (n_in - k >= hist_base) y += cs[n_in - k][k] * xs[n_in - k];
    exp_val[n_in] = y;
    exp_last[n_in] = last;
    n_in++;
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_tvalid = 0;
  endtask

  task automatic drain();
    while (n_out != n_in) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] rd;

  initial begin
    for (int k = 0; k < TAPS; k++) coef_m[k] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    #2;
    // R9: reset state
    chk("R9", "out_tvalid after reset", out_tvalid, 0);
    chk("R9", "in_tready after reset (run bit clear)", in_tready, 0);
    axil_read('0, rd);
    chk("R9", "run bit after reset", rd, 0);
    for (int k = 0; k < TAPS; k++) begin
      axil_read(AW'(4 * (k + 1)), rd);
      chk("R9", "coefficient after reset", rd, 0);
    end

    // R2: readback, masking to DW bits with unused bits zero
    set_coef(0, 32'hFFFF_F800);
    set_coef(1, 32'h0000_07FF);
    set_coef(2, 32'h1234_5001);
    set_coef(3, 32'h0000_0ABC);
    axil_read(12'h004, rd); chk("R2", "coef0 readback", rd, 32'h800);
    axil_read(12'h008, rd); chk("R2", "coef1 readback", rd, 32'h7FF);
    axil_read(12'h00C, rd); chk("R2", "coef2 readback", rd, 32'h001);
    axil_read(12'h010, rd); chk("R2", "coef3 readback", rd, 32'hABC);
    set_run(1);
    axil_read('0, rd); chk("R2", "run bit readback", rd, 1);

    // R4: unmapped offsets
    axil_read(12'h014, rd); chk("R4", "unmapped read 0x14", rd, 0);
    axil_read(12'h100, rd); chk("R4", "unmapped read 0x100", rd, 0);
    axil_write(12'h014, 32'hFFFF_FFFF, 4'hF);
    axil_read(12'h010, rd); chk("R4", "coef3 after unmapped write", rd, 32'hABC);
    axil_read(12'h004, rd); chk("R4", "coef0 after unmapped write", rd, 32'h800);

    // R3: byte strobes
    set_coef(0, 32'h0000_0123);
    axil_write(12'h004, 32'h0000_0ABC, 4'b0010);
    axil_read(12'h004, rd); chk("R3", "strobe byte1 only", rd, 32'hA23);
    axil_write(12'h004, 32'h0000_0777, 4'b0000);
    axil_read(12'h004, rd); chk("R3", "strobe none", rd, 32'hA23);
    axil_write(12'h004, 32'h0000_0F55, 4'b0001);
    axil_read(12'h004, rd); chk("R3", "strobe byte0 only", rd, 32'hA55);
    axil_write('0, 32'h0000_0000, 4'b0000);
    axil_read('0, rd); chk("R3", "run bit kept without strobe", rd, 1);

    // R5: run bit clear blocks input
    set_run(0);
    @(negedge clk);
    in_tdata = 32'h0000_0123; in_tvalid = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chk("R5", "in_tready with run clear", in_tready, 0);
      chk("R5", "no output with run clear", out_tvalid, 0);
    end
    idle_in();

    // R1: impulse response
    set_coef(0, 32'd3);
    set_coef(1, 32'hFFFF_FFFB);
    set_coef(2, 32'd7);
    set_coef(3, 32'd11);
    set_run(1);
    push(12'd1, 0);
    #1;
    chk("R1", "out_tvalid on accepting edge", out_tvalid, 1);
    for (int i = 0; i < 5; i++) push(12'd0, i == 4);
    idle_in();
    drain();

    // R1: exhaustive sweep of all input codes with extreme coefficients
    set_coef(0, 32'h0000_0800);
    set_coef(1, 32'h0000_07FF);
    set_coef(2, 32'h0000_0FFF);
    set_coef(3, 32'd1000);
    for (int v = 0; v < 4096; v++) push(12'(v + 2048), (v % 64) == 63);
    push(12'h800, 0); push(12'h800, 0); push(12'h800, 0); push(12'h800, 1);
    idle_in();
    drain();

    // R5: full output blocks input
    bp_mode = 2;
    push(12'd100, 0);
    @(negedge clk);
    in_tdata = {20'h0, 12'd200}; in_tvalid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R5", "in_tready with output stalled", in_tready, 0);
      chk("R6", "stalled output still valid", out_tvalid, 1);
    end
    bp_mode = 0;
    push(12'd200, 1);
    idle_in();
    drain();

    // R6: pseudo-random back-pressure, nothing lost
    bp_mode = 1;
    for (int i = 0; i < 200; i++) push(12'((i * 1237 + 91) % 4096), (i % 13) == 12);
    idle_in();
    drain();
    bp_mode = 0;
    chk("R6", "outputs equal inputs after back-pressure", n_out, n_in);

    // R8: coefficient change with history held
    for (int i = 0; i < 3; i++) push(12'(300 + 17 * i), 0);
    idle_in();
    set_coef(2, 32'hFFFF_FF9C);
    set_coef(0, 32'd45);
    for (int i = 0; i < 5; i++) push(12'(4000 - 29 * i), i == 4);
    idle_in();
    drain();
    chk("R8", "beats after coefficient change", n_out, n_in);

    // R9: reset mid-run clears partial sums
    push(12'd900, 0); push(12'd901, 0);
    idle_in();
    drain();
    do_reset();
    #2;
    chk("R9", "out_tvalid after mid-run reset", out_tvalid, 0);
    axil_read(12'h00C, rd); chk("R9", "coef2 cleared by reset", rd, 0);
    set_coef(0, 32'd5);
    set_coef(1, 32'd6);
    set_run(1);
    push(12'd2, 0); push(12'd0, 0); push(12'd0, 1);
    idle_in();
    drain();

    finish_run();
  end
endmodule